// File: doc/BRIEF.md
# Scanline Video Streamer with Palette Lookup

This block plays out one visible scan line of pixels to a 32-bit DAC bus, which holds four 8-bit converter lanes. It reads pixel data from a word-wide memory port and issues one new pixel every N system clocks. There are six pixel formats. In the two direct formats the pixel drives the DAC bus itself. In the four packed formats, 8, 4, 2 and 1 bits wide, each pixel is an index into a 256-entry table of 32-bit DAC patterns held in local RAM.

A command gives a format, a divider, a start word address and a pixel count, and produces exactly one line. Commands are never chained. When the line ends, the DAC bus returns to a programmable rest value, the idle pattern, which is used for blanking and sync levels between lines. All logic runs on the system clock, and there is no decoupling FIFO. Both read ports are combinational: the memory data must follow the memory address within the same cycle, and the table data must follow the table address within the same cycle.

Top module: `video_line_streamer`

## Requirements
- R1: While reset is asserted and after it is released, `dac_out` is zero and `busy` is low.
- R2: A command is accepted when `cmd_valid` is high, `busy` is low and `cmd_count` is nonzero. `busy` rises at the accepting edge and stays high for count*N+1 cycles.
- R3: Pixel k (counting from 0) appears on `dac_out` at clock edge 1+k*N after the accepting edge and holds for exactly N cycles.
- R4: A `cmd_div` value of 0 behaves exactly like a value of 1.
- R5: `cmd_mode` 0 is the 32-bit direct format: each memory word is one pixel and goes to `dac_out` unchanged. Mode values 6 and 7 behave as mode 0.
- R6: `cmd_mode` 1 is the 16-bit direct format. The low half of a word is shown first, then the high half. Each pixel is zero-extended into bits 15:0 of `dac_out`.
- R7: `cmd_mode` 2, 3, 4 and 5 select 8-, 4-, 2- and 1-bit pixels. These pixels are unpacked from each word starting at bit 0, and each one is zero-extended onto `lut_addr`. `dac_out` shows `lut_rdata` for that pixel.
- R8: `mem_addr` starts at `cmd_addr`. It advances by one word only after the last pixel of the current word has been shown. While pixel k is on the bus, it equals `cmd_addr + (k+1)/pixels_per_word`.
- R9: At the edge that ends the line, `dac_out` takes the idle pattern and `busy` falls.
- R10: A write to the idle pattern (`idle_wr`) while `busy` is low appears on `dac_out` at the next edge.
- R11: A write to the idle pattern while `busy` is high leaves the pixels unchanged. The last value written is shown when the line ends.
- R12: A command with `cmd_count` of zero leaves `busy` low and `dac_out` unchanged.
- R13: A command presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Start-line request |
| cmd_mode | input | 3 | Pixel format code |
| cmd_div | input | DIV_W | Clocks per pixel (0 acts as 1) |
| cmd_addr | input | ADDR_W | First memory word address |
| cmd_count | input | CNT_W | Pixels in the line |
| idle_wr | input | 1 | Write strobe for the idle pattern |
| idle_data | input | DATA_W | New idle pattern |
| mem_addr | output | ADDR_W | Memory word address |
| mem_rdata | input | DATA_W | Memory word at `mem_addr` |
| lut_addr | output | LUT_AW | Palette table index |
| lut_rdata | input | DATA_W | Table entry at `lut_addr` |
| dac_out | output | DATA_W | Four 8-bit DAC lanes |
| busy | output | 1 | Line in progress |

## Verification
The hardest cases to reach are the word boundaries in the 1-bit and 2-bit formats. A fetch that comes one pixel early or late only shows up once a line runs past 16 or 32 pixels. The bench sweeps every format code, including the two spare ones, over several dividers and three line lengths: one pixel, one word plus one pixel, and two words plus three pixels. It checks each cycle against values it computes from a known memory pattern. Idle-pattern writes and stray commands are injected at chosen cycles in the middle of a line to cover the deferred-update and ignore rules.

// File: rtl/vls_pkg.sv
package vls_pkg;
  localparam int MODE_W   = 3;
  localparam int NUM_FMT  = 6;
  localparam int LUT_FIRST = 2;

  // Map a format code to log2(pixels per word); spare codes fall back to direct 32-bit.
  function automatic logic [MODE_W-1:0] fmt_shift(input logic [MODE_W-1:0] code);
    return (int'(code) >= NUM_FMT) ? '0 : code;
  endfunction
endpackage

// File: rtl/vls_rate_div.sv
module vls_rate_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  input  logic             run,
  output logic             tick
);
  logic [DIV_W-1:0] reload_q, reload_n;
  logic [DIV_W-1:0] cnt_q, cnt_n;
  logic             cnt_en;

  always_comb begin
    reload_n = reload_q;
    cnt_n    = cnt_q;
    cnt_en   = 1'b0;
    if (load) begin
      reload_n = (div_in == '0) ? '0 : div_in - 1'b1;
      cnt_n    = '0;
      cnt_en   = 1'b1;
    end else if (run) begin
      cnt_n  = (cnt_q == '0) ? reload_q : cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      cnt_q    <= '0;
    end else if (cnt_en) begin
      reload_q <= reload_n;
      cnt_q    <= cnt_n;
    end
  end

  assign tick = run && (cnt_q == '0);
endmodule

// File: rtl/vls_unpack.sv
module vls_unpack
  import vls_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic [MODE_W-1:0] shift,
  input  logic [DATA_W-1:0] word,
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] field,
  output logic              last_in_word
);
  logic [DATA_W-1:0] fld [NUM_FMT];

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
    localparam int BPP = DATA_W >> g;
    if (g == 0) begin : g_full
      assign fld[g] = word;
    end else begin : g_part
      logic [g-1:0] sel;
      assign sel    = idx[g-1:0];
      assign fld[g] = DATA_W'(word[int'(sel)*BPP +: BPP]);
    end
  end

  always_comb begin
    field = fld[0];
    for (int i = 1; i < NUM_FMT; i++) begin
      if (shift == MODE_W'(i)) field = fld[i];
    end
  end

  assign last_in_word = (idx == IDX_W'((1 << shift) - 1));
endmodule

// File: rtl/vls_line_ctrl.sv
module vls_line_ctrl
  import vls_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 12,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MODE_W-1:0] st_shift,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [CNT_W-1:0]  st_count,
  input  logic              tick,
  input  logic              last_in_word,
  output logic              busy,
  output logic [MODE_W-1:0] shift_q,
  output logic [ADDR_W-1:0] word_addr,
  output logic [IDX_W-1:0]  idx,
  output logic              emit,
  output logic              done
);
  logic              busy_q, busy_n;
  logic [MODE_W-1:0] shift_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [CNT_W-1:0]  rem_q, rem_n;
  logic              upd_en;

  assign emit = busy_q && tick && (rem_q != '0);
  assign done = busy_q && tick && (rem_q == '0);

  always_comb begin
    busy_n  = busy_q;
    shift_n = shift_q;
    addr_n  = addr_q;
    idx_n   = idx_q;
    rem_n   = rem_q;
    upd_en  = 1'b0;
    if (start) begin
      busy_n  = 1'b1;
      shift_n = st_shift;
      addr_n  = st_addr;
      idx_n   = '0;
      rem_n   = st_count;
      upd_en  = 1'b1;
    end else if (emit) begin
      rem_n  = rem_q - 1'b1;
      upd_en = 1'b1;
      if (last_in_word) begin
        idx_n  = '0;
        addr_n = addr_q + 1'b1;
      end else begin
        idx_n = idx_q + 1'b1;
      end
    end else if (done) begin
      busy_n = 1'b0;
      upd_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      shift_q <= '0;
      addr_q  <= '0;
      idx_q   <= '0;
      rem_q   <= '0;
    end else if (upd_en) begin
      busy_q  <= busy_n;
      shift_q <= shift_n;
      addr_q  <= addr_n;
      idx_q   <= idx_n;
      rem_q   <= rem_n;
    end
  end

  assign busy      = busy_q;
  assign word_addr = addr_q;
  assign idx       = idx_q;
endmodule

// File: rtl/video_line_streamer.sv
module video_line_streamer
  import vls_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 12,
  parameter int DIV_W  = 8,
  parameter int DATA_W = 32,
  parameter int LUT_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_mode,
  input  logic [DIV_W-1:0]  cmd_div,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic              idle_wr,
  input  logic [DATA_W-1:0] idle_data,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [LUT_AW-1:0] lut_addr,
  input  logic [DATA_W-1:0] lut_rdata,
  output logic [DATA_W-1:0] dac_out,
  output logic              busy
);
  localparam int IDX_W = $clog2(DATA_W);

  logic              accept, tick, emit, done, last_in_word, use_lut;
  logic [MODE_W-1:0] line_mode;
  logic [IDX_W-1:0]  pix_idx;
  logic [DATA_W-1:0] field;
  logic [DATA_W-1:0] idle_q, idle_n, dac_q, dac_n;
  logic              idle_en, dac_en;

  assign accept = cmd_valid && !busy && (cmd_count != '0);

  vls_rate_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .load(accept), .div_in(cmd_div),
    .run(busy), .tick(tick)
  );

  vls_line_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(accept), .st_shift(fmt_shift(cmd_mode)),
    .st_addr(cmd_addr), .st_count(cmd_count), .tick(tick),
    .last_in_word(last_in_word), .busy(busy), .shift_q(line_mode),
    .word_addr(mem_addr), .idx(pix_idx), .emit(emit), .done(done)
  );

  vls_unpack #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_unpack (
    .shift(line_mode), .word(mem_rdata), .idx(pix_idx),
    .field(field), .last_in_word(last_in_word)
  );

  assign use_lut  = (int'(line_mode) >= LUT_FIRST);
  assign lut_addr = field[LUT_AW-1:0];

  // Idle pattern: always captured, shown immediately only when no line runs.
  always_comb begin
    idle_n  = idle_wr ? idle_data : idle_q;
    idle_en = idle_wr;
    dac_n   = dac_q;
    dac_en  = 1'b0;
    if (emit) begin
      dac_n  = use_lut ? lut_rdata : field;
      dac_en = 1'b1;
    end else if (done) begin
      dac_n  = idle_n;
      dac_en = 1'b1;
    end else if (!busy && idle_wr) begin
      dac_n  = idle_data;
      dac_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= '0;
    end else if (idle_en) begin
      idle_q <= idle_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_q <= '0;
    end else if (dac_en) begin
      dac_q <= dac_n;
    end
  end

  assign dac_out = dac_q;
endmodule

// File: rtl/vls_chk.sv
module vls_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 12,
  parameter int DATA_W = 32,
  parameter int LUT_AW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [CNT_W-1:0]  cmd_count,
  input logic              idle_wr,
  input logic [DATA_W-1:0] idle_data,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [LUT_AW-1:0] lut_addr,
  input logic [DATA_W-1:0] dac_out,
  input logic              busy,
  input logic [2:0]        line_mode,
  input logic [DATA_W-1:0] idle_q
);
  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(cmd_valid) && ($past(cmd_count) != '0)));

  // R12
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && (cmd_count == '0) && !idle_wr) |=> (!busy && $stable(dac_out)));

  // R9
  line_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (dac_out == idle_q));

  // R10
  idle_show_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && idle_wr) |=> (dac_out == $past(idle_data)));

  // R7
  one_bit_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (line_mode == 3'd5)) |-> (lut_addr <= LUT_AW'(1)));

  // R8
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (mem_addr != $past(mem_addr)))
      |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));
endmodule

bind video_line_streamer vls_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .LUT_AW(LUT_AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_count(cmd_count),
  .idle_wr(idle_wr), .idle_data(idle_data), .mem_addr(mem_addr),
  .lut_addr(lut_addr), .dac_out(dac_out), .busy(busy),
  .line_mode(line_mode), .idle_q(idle_q)
);

// File: tb/video_line_streamer_tb.sv
`timescale 1ns/1ps
module video_line_streamer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_mode = '0;
  logic [7:0]  cmd_div = '0;
  logic [15:0] cmd_addr = '0;
  logic [11:0] cmd_count = '0;
  logic        idle_wr = 1'b0;
  logic [31:0] idle_data = '0;
  logic [15:0] mem_addr;
  logic [31:0] mem_rdata;
  logic [7:0]  lut_addr;
  logic [31:0] lut_rdata;
  logic [31:0] dac_out;
  logic        busy;

  int checks = 0;
  int errors = 0;
  logic [31:0] mem [64];
  logic [31:0] cur_idle = '0;

  always #2 clk = ~clk;

  video_line_streamer u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
    .cmd_div(cmd_div), .cmd_addr(cmd_addr), .cmd_count(cmd_count),
    .idle_wr(idle_wr), .idle_data(idle_data), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .lut_addr(lut_addr), .lut_rdata(lut_rdata),
    .dac_out(dac_out), .busy(busy)
  );

  function automatic logic [31:0] lut_fn(input logic [7:0] a);
    return {a ^ 8'hC3, a + 8'd17, ~a, a};
  endfunction

  assign mem_rdata = mem[mem_addr[5:0]];
  assign lut_rdata = lut_fn(lut_addr);

  function automatic int shift_of(input int mode);
    return (mode > 5) ? 0 : mode;
  endfunction

  function automatic logic [31:0] exp_pix(input int mode, input int addr, input int k);
    int sh, ppw, bpp;
    logic [31:0] w, f, mask;
    sh   = shift_of(mode);
    ppw  = 1 << sh;
    bpp  = 32 >> sh;
    w    = mem[(addr + k / ppw) & 63];
    mask = (bpp == 32) ? 32'hFFFF_FFFF : 32'((64'd1 << bpp) - 1);
    f    = (w >> ((k % ppw) * bpp)) & mask;
    return (sh < 2) ? f : lut_fn(f[7:0]);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string fmt_req(input int mode);
    if (shift_of(mode) == 0) return "R5/R3";
    if (mode == 1) return "R6/R3";
    return "R7/R3";
  endfunction

  task automatic run_line(input int mode, input int div, input int addr, input int count,
                          input int idle_at, input logic [31:0] new_idle, input int inject_at);
    int n, total, ppw;
    n     = (div == 0) ? 1 : div;
    total = count * n;
    ppw   = 1 << shift_of(mode);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_mode = 3'(mode); cmd_div = 8'(div);
    cmd_addr = 16'(addr); cmd_count = 12'(count);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b1, "R2 busy after accept", 32'(busy), 32'd1);
    for (int c = 1; c <= total + 1; c++) begin
      if (c == idle_at) begin
        idle_wr = 1'b1; idle_data = new_idle; cur_idle = new_idle;
      end
      if (c == inject_at) begin
        cmd_valid = 1'b1; cmd_mode = 3'(5 - (mode % 6)); cmd_div = 8'd1;
        cmd_addr = 16'd40; cmd_count = 12'd9;
      end
      @(negedge clk);
      idle_wr = 1'b0; cmd_valid = 1'b0;
      if (c <= total) begin
        int k;
        k = (c - 1) / n;
        chk(dac_out == exp_pix(mode, addr, k), fmt_req(mode), dac_out, exp_pix(mode, addr, k));
        chk(busy == 1'b1, "R2 busy held", 32'(busy), 32'd1);
        chk(mem_addr == 16'(addr + (k + 1) / ppw), "R8 word address", 32'(mem_addr),
            32'(16'(addr + (k + 1) / ppw)));
      end else begin
        chk(dac_out == cur_idle, "R9/R11 idle at end", dac_out, cur_idle);
        chk(busy == 1'b0, "R9 busy falls", 32'(busy), 32'd0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = (32'(i) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    repeat (3) @(negedge clk);
    chk(dac_out == 32'd0, "R1 dac in reset", dac_out, 32'd0);
    chk(busy == 1'b0, "R1 busy in reset", 32'(busy), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dac_out == 32'd0, "R1 dac after reset", dac_out, 32'd0);
    chk(busy == 1'b0, "R1 busy after reset", 32'(busy), 32'd0);

    // R10: idle write while no line is running
    idle_wr = 1'b1; idle_data = 32'h1122_3344; cur_idle = 32'h1122_3344;
    @(negedge clk);
    idle_wr = 1'b0;
    chk(dac_out == 32'h1122_3344, "R10 idle shown", dac_out, 32'h1122_3344);

    // R12: zero-length command
    cmd_valid = 1'b1; cmd_mode = 3'd2; cmd_div = 8'd2; cmd_addr = 16'd3; cmd_count = 12'd0;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk(busy == 1'b0, "R12 no busy", 32'(busy), 32'd0);
      chk(dac_out == cur_idle, "R12 dac unchanged", dac_out, cur_idle);
      @(negedge clk);
    end

    // Sweep all format codes (R5 R6 R7), dividers incl. 0 (R4), lengths across word edges
    for (int mode = 0; mode < 8; mode++) begin
      for (int div = 0; div < 4; div++) begin
        for (int ci = 0; ci < 3; ci++) begin
          int ppw, cnt;
          ppw = 1 << shift_of(mode);
          cnt = (ci == 0) ? 1 : (ci == 1) ? ppw + 1 : 2 * ppw + 3;
          run_line(mode, div, (mode * 9 + div * 5 + ci * 11) % 64, cnt, -1, '0, -1);
        end
      end
    end

    // R11: idle writes during a line, last one wins
    run_line(3, 2, 7, 12, 5, 32'hDEAD_BEEF, -1);
    run_line(4, 1, 20, 20, 9, 32'h0F0F_A5A5, -1);
    run_line(1, 3, 30, 4, 12, 32'h7777_0001, -1);
    run_line(2, 2, 12, 5, 11, 32'hCAFE_0042, -1);

    // R13: command during a line is ignored
    run_line(2, 2, 11, 10, -1, '0, 6);
    run_line(5, 1, 50, 40, -1, '0, 17);
    repeat (2) @(negedge clk);
    chk(busy == 1'b0, "R13 no late start", 32'(busy), 32'd0);
    chk(dac_out == cur_idle, "R13 dac idle", dac_out, cur_idle);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule